// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Bank

This block is one bank of general-purpose pins behind a small memory-mapped register window. Software chooses the direction of each pin and changes output levels only through write-one set and clear registers, so two agents can update different pins without a read-modify-write race. Input levels pass through a two-flop synchronizer before software can read them back. This applies to every pin, including pins that currently drive an output.

Each pin has a rising-edge enable and a falling-edge enable. Software changes both masks only through set and clear registers. An enabled transition on a synchronized pin latches a status bit, and software clears that bit by writing one to it. The status bits are split into a low half and a high half. Each half drives its own level interrupt line, and each line has its own enable bit. A configurable number of low pins also give a one-cycle direct pulse for every enabled edge. These pulses do not depend on the half enables.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` all zero), `pin_out` is zero, both edge masks are zero, status is zero, both half enables are zero, and neither interrupt output is high.
- R2: The direction register at offset 0x10 holds 1 for input and 0 for output per pin, and `pin_oe` is the bitwise inverse of it.
- R3: A write to offset 0x18 sets the output bits that are 1 in the data, a write to 0x1C clears them, and 0 bits are unchanged. Offset 0x14 reads the output levels, and writes to 0x14 are ignored.
- R4: Offset 0x20 reads the pin levels through a two-flop synchronizer: a pin change made before clock edge k is read from edge k+1 on. This holds regardless of direction.
- R5: The rising mask is set by ones written to 0x24 and cleared by ones written to 0x28. The falling mask is set at 0x2C and cleared at 0x30. Both addresses of a pair read back the current mask, and the masks change only through these writes.
- R6: A synchronized transition latches the pin's status bit only when the mask for that direction is set. With both masks set, either direction latches it. With neither set, nothing latches.
- R7: Writing 1 to a bit at 0x34 (the status register) clears it, and 0 bits are unchanged. If an edge event for that pin lands in the same cycle as the clear write, the bit stays set.
- R8: Bits 0 and 1 at offset 0x08 enable `irq_half[0]` and `irq_half[1]`. `irq_half[0]` is high while enabled and any status bit 15:0 is set. `irq_half[1]` does the same for bits 31:16.
- R9: For each pin below DIRECT_N, `irq_direct` gives a one-cycle pulse for every enabled edge. It is high in the cycle after clock edge k+2 when the pin changed before edge k, and the half enables do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, one register write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output drive levels |
| pin_oe | output | NPINS | Output enables, 1 drives the pin |
| irq_half | output | 2 | Per-half level interrupts |
| irq_direct | output | DIRECT_N | Per-pin edge pulses for the low pins |

## Verification
A wrong status bit shows within one cycle on the half-bank line and on a read of 0x34. A missing or extra event therefore appears three cycles after the pin changes, and a lost collision appears one cycle after the clear write. A wrong edge mask produces no visible error until a pin toggles, so the random stimulus interleaves mask changes with pin toggles and compares every status readback with a model. A synchronizer with the wrong depth shifts the input readback and the direct pulse by a cycle, and directed checks sample at those exact cycles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFF_HEN   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_OUT   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SET   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_IN    = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_SRISE = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_CRISE = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_SFALL = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_CFALL = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h34;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // Per-pin event: a rise gated by its mask or a fall gated by its mask.
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign evt[i] = (level[i] & ~prev_q[i] & rise_en[i]) |
                        (~level[i] & prev_q[i] & fall_en[i]);
    end

    // R6: no event may appear while the sampled level holds still
    a_r6_quiet_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (level == prev_q) |-> (evt == '0));
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
    parameter int W  = 32,
    parameter int DN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  stat,
    input  logic [W-1:0]  evt,
    input  logic [1:0]    half_en,
    output logic [1:0]    irq_half,
    output logic [DN-1:0] irq_direct
);
    localparam int HALF = W / 2;

    logic [DN-1:0] pulse_d, pulse_q;

    always_comb begin
        pulse_d = evt[DN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= pulse_d;
    end

    assign irq_half[0] = half_en[0] & (|stat[HALF-1:0]);
    assign irq_half[1] = half_en[1] & (|stat[W-1:HALF]);
    assign irq_direct  = pulse_q;

    // R9: a direct pulse needs an event on the cycle before it
    a_r9_pulse_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[DN-1:0] == '0) |=> (irq_direct == '0));
    // R8: a disabled half never raises its line
    a_r8_low_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !half_en[0] |-> !irq_half[0]);
    a_r8_high_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !half_en[1] |-> !irq_half[1]);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter int DIRECT_N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr_en,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_out,
    output logic [NPINS-1:0]    pin_oe,
    output logic [1:0]          irq_half,
    output logic [DIRECT_N-1:0] irq_direct
);
    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] rise;
        logic [NPINS-1:0] fall;
        logic [NPINS-1:0] stat;
        logic [1:0]       hen;
    } bank_t;

    bank_t s_d, s_q;

    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] evt;
    logic [NPINS-1:0] wmask;

    assign wmask = bus_wdata[NPINS-1:0];

    gpio_bank_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_bank_edge #(.W(NPINS)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (pin_sync),
        .rise_en (s_q.rise),
        .fall_en (s_q.fall),
        .evt     (evt)
    );

    gpio_bank_irq #(.W(NPINS), .DN(DIRECT_N)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat       (s_q.stat),
        .evt        (evt),
        .half_en    (s_q.hen),
        .irq_half   (irq_half),
        .irq_direct (irq_direct)
    );

    always_comb begin
        logic [NPINS-1:0] stat_clr;
        s_d      = s_q;
        stat_clr = '0;
        if (bus_wr_en) begin
            case (bus_addr)
                OFF_HEN:   s_d.hen  = bus_wdata[1:0];
                OFF_DIR:   s_d.dir  = wmask;
                OFF_SET:   s_d.dout = s_q.dout | wmask;
                OFF_CLR:   s_d.dout = s_q.dout & ~wmask;
                OFF_SRISE: s_d.rise = s_q.rise | wmask;
                OFF_CRISE: s_d.rise = s_q.rise & ~wmask;
                OFF_SFALL: s_d.fall = s_q.fall | wmask;
                OFF_CFALL: s_d.fall = s_q.fall & ~wmask;
                OFF_STAT:  stat_clr = wmask;
                default:   ;
            endcase
        end
        // A new event outranks a clear in the same cycle.
        s_d.stat = (s_q.stat & ~stat_clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.dir <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_HEN:              bus_rdata = 32'(s_q.hen);
            OFF_DIR:              bus_rdata = 32'(s_q.dir);
            OFF_OUT, OFF_SET,
            OFF_CLR:              bus_rdata = 32'(s_q.dout);
            OFF_IN:               bus_rdata = 32'(pin_sync);
            OFF_SRISE, OFF_CRISE: bus_rdata = 32'(s_q.rise);
            OFF_SFALL, OFF_CFALL: bus_rdata = 32'(s_q.fall);
            OFF_STAT:             bus_rdata = 32'(s_q.stat);
            default:              bus_rdata = '0;
        endcase
    end

    assign pin_out = s_q.dout;
    assign pin_oe  = ~s_q.dir;

    // R3: output levels move only on a set or clear write
    a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && (bus_addr == OFF_SET || bus_addr == OFF_CLR)) |=> $stable(pin_out));
    // R5: edge masks move only on their own set/clear writes
    a_r5_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && (bus_addr == OFF_SRISE || bus_addr == OFF_CRISE)) |=> $stable(s_q.rise));
    a_r5_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && (bus_addr == OFF_SFALL || bus_addr == OFF_CFALL)) |=> $stable(s_q.fall));
    // R6: status only gains bits from an event
    a_r6_stat_from_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> ((s_q.stat & ~$past(s_q.stat)) == '0));
    // R7: an event always leaves its status bit set
    a_r7_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((s_q.stat & $past(evt)) == $past(evt)));
endmodule

// File: tb/gpio_edge_bank_bench.sv
module gpio_edge_bank_bench;
    import gpio_bank_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int DN = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr_en = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_out;
    logic [NP-1:0]     pin_oe;
    logic [1:0]        irq_half;
    logic [DN-1:0]     irq_direct;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_dir, m_out, m_rise, m_fall, m_stat, m_pins;
    logic [1:0]  m_hen;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank #(.NPINS(NP), .DIRECT_N(DN)) u_gpio_edge_bank (
        .clk, .rst_n, .bus_addr, .bus_wr_en, .bus_wdata, .bus_rdata,
        .pin_in, .pin_out, .pin_oe, .irq_half, .irq_direct
    );

    function automatic logic [1:0] exp_irq(logic [31:0] st, logic [1:0] hen);
        return {hen[1] & (|st[31:16]), hen[0] & (|st[15:0])};
    endfunction

    function automatic logic [31:0] exp_evt(logic [31:0] oldp, logic [31:0] newp,
                                            logic [31:0] r, logic [31:0] f);
        return (newp & ~oldp & r) | (~newp & oldp & f);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_pins(logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
        m_stat |= exp_evt(m_pins, v, m_rise, m_fall);
        m_pins = v;
    endtask

    task automatic check_all(string tag);
        logic [31:0] d;
        rd(OFF_STAT, d);  chk({tag, " R6 status"}, d, m_stat);
        rd(OFF_SRISE, d); chk({tag, " R5 rise mask"}, d, m_rise);
        rd(OFF_CFALL, d); chk({tag, " R5 fall mask"}, d, m_fall);
        rd(OFF_IN, d);    chk({tag, " R4 in"}, d, m_pins);
        rd(OFF_OUT, d);   chk({tag, " R3 out"}, d, m_out);
        chk({tag, " R3 pin_out"}, pin_out, m_out);
        chk({tag, " R2 pin_oe"}, pin_oe, ~m_dir);
        chk({tag, " R8 irq_half"}, 32'(irq_half), 32'(exp_irq(m_stat, m_hen)));
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        m_dir = '1; m_out = '0; m_rise = '0; m_fall = '0; m_stat = '0;
        m_pins = '0; m_hen = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(OFF_DIR, d);  chk("R1 dir", d, 32'hFFFF_FFFF);
        rd(OFF_HEN, d);  chk("R1 half enable", d, 32'h0);
        chk("R1 irq_direct", 32'(irq_direct), 32'h0);
        check_all("R1");

        // R2 direction
        wr(OFF_DIR, 32'h0F0F_00FF); m_dir = 32'h0F0F_00FF;
        rd(OFF_DIR, d); chk("R2 dir readback", d, m_dir);
        chk("R2 oe", pin_oe, ~m_dir);

        // R3 set/clear and ignored out write
        wr(OFF_SET, 32'h8000_0011); m_out |= 32'h8000_0011;
        wr(OFF_CLR, 32'h0000_0010); m_out &= ~32'h0000_0010;
        wr(OFF_OUT, 32'hFFFF_FFFF);
        rd(OFF_OUT, d); chk("R3 out write ignored", d, m_out);
        chk("R3 pin_out", pin_out, 32'h8000_0001);

        // R4 input readback timing, no masks enabled yet
        @(negedge clk);
        pin_in = 32'h0000_0008;
        @(negedge clk);
        rd(OFF_IN, d); chk("R4 one edge still old", d, 32'h0);
        @(negedge clk);
        rd(OFF_IN, d); chk("R4 after two edges", d, 32'h8);
        repeat (2) @(negedge clk);
        m_pins = 32'h8;
        check_all("R4 no mask no status");

        // R9 direct pulse timing and R7 collision, pin 2 rising
        wr(OFF_SRISE, 32'h0000_0024); m_rise |= 32'h24;
        @(negedge clk);
        pin_in = m_pins | 32'h4;
        @(negedge clk);
        chk("R9 no pulse early", 32'(irq_direct), 32'h0);
        @(negedge clk);
        chk("R9 no pulse at k+2 sample", 32'(irq_direct), 32'h0);
        @(negedge clk);
        chk("R9 pulse", 32'(irq_direct), 32'h4);
        @(negedge clk);
        chk("R9 pulse one cycle", 32'(irq_direct), 32'h0);
        m_pins |= 32'h4; m_stat |= 32'h4;
        check_all("R6 rise latched");

        // R7 collision: clear write lands with pin 5 event
        @(negedge clk);
        pin_in = m_pins | 32'h20;
        @(negedge clk);
        @(negedge clk);
        bus_addr = OFF_STAT; bus_wdata = 32'h24; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        m_pins |= 32'h20;
        m_stat = (m_stat & ~32'h24) | 32'h20;
        rd(OFF_STAT, d); chk("R7 edge beats clear", d, m_stat);

        // R8 gating
        chk("R8 disabled", 32'(irq_half), 32'h0);
        wr(OFF_HEN, 32'h1); m_hen = 2'b01;
        chk("R8 low enabled", 32'(irq_half), 32'h1);
        wr(OFF_STAT, 32'hFFFF_FFFF); m_stat = '0;
        chk("R7 w1c all", 32'(irq_half), 32'h0);

        // R6 both edges on pin 20
        wr(OFF_SRISE, 32'h0010_0000); m_rise |= 32'h0010_0000;
        wr(OFF_SFALL, 32'h0010_0000); m_fall |= 32'h0010_0000;
        wr(OFF_HEN, 32'h3); m_hen = 2'b11;
        set_pins(m_pins | 32'h0010_0000);
        check_all("R6 both rise");
        wr(OFF_STAT, 32'h0010_0000); m_stat &= ~32'h0010_0000;
        set_pins(m_pins & ~32'h0010_0000);
        check_all("R6 both fall");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op;
            logic [31:0] r;
            op = int'($urandom_range(0, 7));
            r  = $urandom();
            case (op)
                0: begin wr(OFF_SRISE, r); m_rise |= r; end
                1: begin wr(OFF_CRISE, r); m_rise &= ~r; end
                2: begin wr(OFF_SFALL, r); m_fall |= r; end
                3: begin wr(OFF_CFALL, r); m_fall &= ~r; end
                4: begin wr(OFF_STAT, r);  m_stat &= ~r; end
                5: begin wr(OFF_HEN, r);   m_hen = r[1:0]; end
                6: begin
                    if (r[0]) begin wr(OFF_SET, $urandom()); end
                    else      begin wr(OFF_DIR, r); m_dir = r; end
                    rd(OFF_OUT, d); m_out = d;
                end
                default: set_pins(m_pins ^ $urandom());
            endcase
            if (op == 6) chk("R3 random out", pin_out, m_out);
            check_all("random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule